// File: doc/BRIEF.md
# Display Controller Configuration Target

This block is the register file inside a panel driver chip. A serial front end (not part of this block) decodes bus transactions and presents each received byte as a write strobe with an address and a data byte, and each byte the host wants to fetch as a read strobe. Writes store the data byte ANDed with the destination's valid-bit mask. Reads do not address a register directly. The host first loads a read pointer. Each later pair of read strobes then returns the pointer value, followed by the byte at that pointer. The pointer advances after the data byte.

Two key registers each open a hidden factory bank when they hold the magic key value. The first key opens a small bank that overlays a range of normal addresses. The second key opens alternate image and interface configuration registers at the addresses of the normal ones. Any other key value closes the bank again. Stored contents survive both locking and unlocking.

A 0-to-1 transition on a trigger bit starts a checksum. The checksum is the XOR of six normal configuration registers, processed one register per clock. A status register reports that the checksum is busy, and the result lands in its own read-only register. The block also exposes a fixed controller identity byte and an initialisation-done flag.

Top module: `lcd_cfg_target`

## Requirements
- R1: After reset every writable register and both key registers read 0x00, the read pointer is 0x00, the next read returns the pointer, and the status (0x55) and checksum (0x61) read 0x00; register 0x62 reads 0x00 until INIT_CYCLES clocks after reset, then reads 0x01.
- R2: A write stores data AND mask, with these masks: 0x01→0x11 (display enable; 0x00 off slow discharge, 0x01 off fast discharge, 0x10 on using colour input, 0x11 on with inputs ignored), 0x10→0xF7, 0x11→0x7F, 0x50→0x11, 0x53→0x73, 0x54→0x01, 0x60→0x01, 0xFE→0xFF.
- R3: A write to 0x40 loads the read pointer and makes the next read an address read. Reads alternate between the pointer value and the byte at that pointer. The pointer increments by one after each data read and wraps from 0xFF to 0x00. Reading address 0x40 returns the current pointer.
- R4: While key register 0xAF holds 0xAA, addresses 0x50–0x53 map to a factory bank of full 8-bit registers. Any other value in 0xAF restores the normal view with the normal contents intact, and the factory contents are retained for the next unlock.
- R5: While key register 0x03 holds 0xAA, addresses 0x10 and 0x11 map to factory registers masked with 0xD7 and 0x7F. Any other value restores the normal registers unchanged.
- R6: Both key registers store and read back the full written byte.
- R7: A write that takes 0x54 bit0 from 0 to 1 starts a checksum while none is running. Register 0x55 then reads 0x01 until the checksum finishes and 0x00 otherwise. Writing 1 when bit0 is already 1 starts nothing.
- R8: The checksum stored in 0x61 is the XOR of the normal (never the factory) registers 0x01, 0x10, 0x11, 0x50, 0x53 and 0x60. It completes six clocks after the starting write.
- R9: Register 0xFF reads {MFR_CODE, REV_CODE} (0xC7 by default). Writes to 0xFF, 0x55, 0x61 and 0x62 have no effect.
- R10: Unmapped addresses read 0x00, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Byte read strobe |
| rd_data | output | 8 | Read byte (pointer or data), valid the cycle after rd_en |

## Verification
Every masked register is swept through all 256 data values and read back, which separates a wrong mask bit from a missing write. Every address receives an address-derived byte, and then the whole map is read in one auto-incrementing burst. That separates unmapped, read-only and writable addresses and shows that the pointer and data alternate correctly. Lock, unlock and relock sequences use distinct factory and normal values, so a leaking overlay cannot pass. Checksums are started with the factory view open, to confirm that only normal values feed the result. A repeated trigger write with bit0 already set confirms that only a true 0-to-1 transition starts a checksum.

// File: rtl/lcd_cfg_target.sv
module lcd_cfg_target #(
  parameter logic [3:0] MFR_CODE    = 4'hC,
  parameter logic [3:0] REV_CODE    = 4'h7,
  parameter int         INIT_CYCLES = 16,
  parameter logic [7:0] UNLOCK_KEY  = 8'hAA,
  parameter logic [7:0] FBANK_BASE  = 8'h50,
  parameter int         FBANK_N     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data
);
  localparam logic [7:0] A_DISP = 8'h01, A_KEYB = 8'h03, A_IFC = 8'h10, A_IMG = 8'h11;
  localparam logic [7:0] A_PTR = 8'h40, A_M50 = 8'h50, A_M53 = 8'h53, A_TRIG = 8'h54;
  localparam logic [7:0] A_STAT = 8'h55, A_M60 = 8'h60, A_CSUM = 8'h61, A_RDY = 8'h62;
  localparam logic [7:0] A_KEYA = 8'hAF, A_SCR = 8'hFE, A_ID = 8'hFF;
  localparam int CS_N = 6;
  localparam int FBW  = (FBANK_N > 1) ? $clog2(FBANK_N) : 1;
  localparam int IW   = $clog2(INIT_CYCLES + 1);

  logic [7:0] disp, ifc, img, m50, m53, m60, scr, keya, keyb, fac_ifc, fac_img;
  logic       trig;
  logic [7:0] fbank [FBANK_N];
  logic [7:0] ptr;
  logic       phase;
  logic       busy;
  logic [2:0] cs_idx;
  logic [7:0] cs_acc, csum;
  logic [IW-1:0] init_cnt;

  wire unlock_a = (keya == UNLOCK_KEY);
  wire unlock_b = (keyb == UNLOCK_KEY);
  wire init_done = (init_cnt == IW'(INIT_CYCLES));
  wire start = wr_en && wr_addr == A_TRIG && wr_data[0] && !trig && !busy;

  function automatic logic fb_hit(input logic [7:0] a);
    logic [8:0] off;
    off = {1'b0, a} - {1'b0, FBANK_BASE};
    return off < 9'(FBANK_N);
  endfunction

  function automatic logic [FBW-1:0] fb_idx(input logic [7:0] a);
    logic [7:0] off;
    off = a - FBANK_BASE;
    return off[FBW-1:0];
  endfunction

  function automatic logic [7:0] cs_val(input logic [2:0] i);
    case (i)
      3'd0:    return disp;
      3'd1:    return ifc;
      3'd2:    return img;
      3'd3:    return m50;
      3'd4:    return m53;
      default: return m60;
    endcase
  endfunction

  function automatic logic [7:0] rd_view(input logic [7:0] a);
    if (unlock_a && fb_hit(a)) return fbank[fb_idx(a)];
    if (unlock_b && a == A_IFC) return fac_ifc;
    if (unlock_b && a == A_IMG) return fac_img;
    case (a)
      A_DISP:  return disp;
      A_KEYB:  return keyb;
      A_IFC:   return ifc;
      A_IMG:   return img;
      A_PTR:   return ptr;
      A_M50:   return m50;
      A_M53:   return m53;
      A_TRIG:  return {7'd0, trig};
      A_STAT:  return {7'd0, busy};
      A_M60:   return m60;
      A_CSUM:  return csum;
      A_RDY:   return {7'd0, init_done};
      A_KEYA:  return keya;
      A_SCR:   return scr;
      A_ID:    return {MFR_CODE, REV_CODE};
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp <= '0; ifc <= '0; img <= '0; m50 <= '0; m53 <= '0; m60 <= '0;
      scr <= '0; keya <= '0; keyb <= '0; fac_ifc <= '0; fac_img <= '0; trig <= 1'b0;
      for (int i = 0; i < FBANK_N; i++) fbank[i] <= '0;
    end else if (wr_en) begin
      if (unlock_a && fb_hit(wr_addr)) fbank[fb_idx(wr_addr)] <= wr_data;
      else if (unlock_b && wr_addr == A_IFC) fac_ifc <= wr_data & 8'hD7;
      else if (unlock_b && wr_addr == A_IMG) fac_img <= wr_data & 8'h7F;
      else begin
        case (wr_addr)
          A_DISP:  disp <= wr_data & 8'h11;
          A_KEYB:  keyb <= wr_data;
          A_IFC:   ifc  <= wr_data & 8'hF7;
          A_IMG:   img  <= wr_data & 8'h7F;
          A_M50:   m50  <= wr_data & 8'h11;
          A_M53:   m53  <= wr_data & 8'h73;
          A_TRIG:  trig <= wr_data[0];
          A_M60:   m60  <= wr_data & 8'h01;
          A_KEYA:  keya <= wr_data;
          A_SCR:   scr  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0; phase <= 1'b0; rd_data <= '0;
    end else if (wr_en && wr_addr == A_PTR) begin
      ptr <= wr_data; phase <= 1'b0;
    end else if (rd_en) begin
      rd_data <= phase ? rd_view(ptr) : ptr;
      phase   <= ~phase;
      if (phase) ptr <= ptr + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cs_idx <= '0; cs_acc <= '0; csum <= '0;
    end else if (start) begin
      busy <= 1'b1; cs_idx <= '0; cs_acc <= '0;
    end else if (busy) begin
      cs_acc <= cs_acc ^ cs_val(cs_idx);
      cs_idx <= cs_idx + 3'd1;
      if (cs_idx == 3'(CS_N - 1)) begin
        busy <= 1'b0;
        csum <= cs_acc ^ cs_val(cs_idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) init_cnt <= '0;
    else if (!init_done) init_cnt <= init_cnt + 1'b1;
  end

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && phase && !wr_en |=> ptr == $past(ptr) + 8'd1);
  a_r3_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en |=> phase != $past(phase));
  a_r4_key_relock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == A_KEYA && wr_data != UNLOCK_KEY |=> !unlock_a);
  a_r8_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cs_idx < 3'(CS_N));
  a_r9_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !wr_en && phase && ptr == A_ID && !(unlock_a && fb_hit(A_ID))
    |=> rd_data == {MFR_CODE, REV_CODE});
endmodule

// File: tb/lcd_cfg_target_tb.sv
module lcd_cfg_target_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  logic [7:0] m [256];
  logic [7:0] ra, rv, cs_exp;

  lcd_cfg_target dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data));

  always #10 clk = ~clk;

  function automatic logic [7:0] mask_of(input logic [7:0] a);
    case (a)
      8'h01: return 8'h11; 8'h10: return 8'hF7; 8'h11: return 8'h7F;
      8'h50: return 8'h11; 8'h53: return 8'h73; 8'h54: return 8'h01;
      8'h60: return 8'h01; 8'hFE, 8'h03, 8'hAF: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wrm(input logic [7:0] a, input logic [7:0] d);
    wr(a, d);
    if (mask_of(a) != 8'h00) m[a] = d & mask_of(a);
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; v = rd_data;
  endtask

  task automatic rd2(input logic [7:0] a, output logic [7:0] ao, output logic [7:0] d);
    wr(8'h40, a); rd(ao); rd(d);
  endtask

  function automatic logic [7:0] cs_model();
    return m[8'h01] ^ m[8'h10] ^ m[8'h11] ^ m[8'h50] ^ m[8'h53] ^ m[8'h60];
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    logic [7:0] list [8];
    list = '{8'h01, 8'h10, 8'h11, 8'h50, 8'h53, 8'h60, 8'hFE, 8'h54};
    for (int i = 0; i < 256; i++) m[i] = 8'h00;
    m[8'hFF] = 8'hC7;
    repeat (3) @(negedge clk); rst_n = 1'b1;

    // R1 reset state and init flag before completion
    rd(ra); chk("R1 ptr after reset", ra, 8'h00);
    rd(rv); chk("R1 reg 0x00", rv, 8'h00);
    rd2(8'h62, ra, rv); chk("R1 init not done", rv, 8'h00);
    rd2(8'h01, ra, rv); chk("R1 disp reset", rv, 8'h00);
    rd2(8'h55, ra, rv); chk("R1 status reset", rv, 8'h00);
    rd2(8'hAF, ra, rv); chk("R1 key reset", rv, 8'h00);
    repeat (20) @(negedge clk);
    m[8'h62] = 8'h01;
    rd2(8'h62, ra, rv); chk("R1 init done", rv, 8'h01);

    // R2 full data sweep of every masked register, trigger last
    for (int k = 0; k < 8; k++)
      for (int d = 0; d < 256; d++) begin
        wrm(list[k], 8'(d));
        rd2(list[k], ra, rv);
        chk("R3 addr echo", ra, list[k]);
        chk("R2 masked write", rv, 8'(d) & mask_of(list[k]));
      end
    repeat (10) @(negedge clk);
    m[8'h61] = cs_model();
    rd2(8'h61, ra, rv); chk("R8 checksum after sweep", rv, m[8'h61]);

    // R10 / R9 / R6: write address-derived data everywhere except the pointer
    for (int a = 0; a < 256; a++)
      if (a != 8'h40) wrm(8'(a), 8'(a) ^ 8'h5A);
    wr(8'h40, 8'h00);
    for (int a = 0; a < 256; a++) begin
      rd(ra); chk("R3 burst addr", ra, 8'(a));
      rd(rv);
      chk("R10 R9 R6 burst data", rv, (a == 8'h40) ? 8'h40 : m[a]);
    end
    rd(ra); chk("R3 pointer wrap", ra, 8'h00);

    // R3 wrap across the top
    wr(8'h40, 8'hFE);
    rd(ra); chk("R3 addr FE", ra, 8'hFE); rd(rv); chk("R3 data FE", rv, m[8'hFE]);
    rd(ra); chk("R3 addr FF", ra, 8'hFF); rd(rv); chk("R9 id", rv, 8'hC7);
    rd(ra); chk("R3 addr wraps", ra, 8'h00); rd(rv); chk("R10 reg 00", rv, 8'h00);

    // R4 factory bank overlay
    wrm(8'hAF, 8'hAA);
    for (int i = 0; i < 4; i++) wr(8'(8'h50 + i), 8'(8'hC3 + i));
    for (int i = 0; i < 4; i++) begin
      rd2(8'(8'h50 + i), ra, rv); chk("R4 factory full byte", rv, 8'(8'hC3 + i));
    end
    rd2(8'h10, ra, rv); chk("R4 outside bank untouched", rv, m[8'h10]);
    wr(8'h54, 8'h00); wr(8'h54, 8'h01);
    repeat (10) @(negedge clk);
    rd2(8'h61, ra, rv); chk("R8 checksum uses normal regs (bank A)", rv, cs_model());
    wrm(8'hAF, 8'h01);
    rd2(8'h50, ra, rv); chk("R4 normal restored", rv, m[8'h50]);
    rd2(8'h51, ra, rv); chk("R4 hole when locked", rv, 8'h00);
    rd2(8'hAF, ra, rv); chk("R6 key readback", rv, 8'h01);
    wrm(8'hAF, 8'hAA);
    rd2(8'h52, ra, rv); chk("R4 factory retained", rv, 8'hC5);
    wrm(8'hAF, 8'h00);

    // R5 second factory set
    wrm(8'h03, 8'hAA);
    wr(8'h10, 8'hFF); wr(8'h11, 8'hFF);
    rd2(8'h10, ra, rv); chk("R5 factory ifc mask", rv, 8'hD7);
    rd2(8'h11, ra, rv); chk("R5 factory img mask", rv, 8'h7F);
    wr(8'h54, 8'h00); wr(8'h54, 8'h01);
    repeat (10) @(negedge clk);
    rd2(8'h61, ra, rv); chk("R8 checksum uses normal regs (set B)", rv, cs_model());
    wrm(8'h03, 8'h55);
    rd2(8'h10, ra, rv); chk("R5 normal ifc restored", rv, m[8'h10]);
    rd2(8'h11, ra, rv); chk("R5 normal img restored", rv, m[8'h11]);

    // R7 / R8 busy window and edge-only trigger
    wrm(8'h01, 8'h10); wrm(8'h60, 8'h00);
    wr(8'h54, 8'h00); wr(8'h54, 8'h01);
    rd2(8'h55, ra, rv); chk("R7 busy status", rv, 8'h01);
    repeat (10) @(negedge clk);
    cs_exp = cs_model();
    rd2(8'h55, ra, rv); chk("R7 idle after", rv, 8'h00);
    rd2(8'h61, ra, rv); chk("R8 checksum value", rv, cs_exp);
    wrm(8'h01, 8'h01);
    wr(8'h54, 8'h01);
    rd2(8'h55, ra, rv); chk("R7 no restart without edge", rv, 8'h00);
    repeat (10) @(negedge clk);
    rd2(8'h61, ra, rv); chk("R7 checksum unchanged", rv, cs_exp);
    wr(8'h54, 8'h00); wr(8'h54, 8'h01);
    repeat (10) @(negedge clk);
    rd2(8'h61, ra, rv); chk("R8 checksum new edge", rv, cs_model());

    summary();
  end
endmodule